// File: doc/BRIEF.md
# Interprocessor Interrupt Command Register

This block holds the command that software fills in to send an interrupt message to other processors, or to itself. The command is 64 bits wide and is reached as two 32-bit halves through a simple word-wide register port. Software first writes the upper half, which holds the target processor number. It then writes the lower half, which holds the vector, message kind, addressing mode, level, trigger kind and shorthand. That second write is itself the send request: no separate "go" bit exists.

Once a message is launched, it is captured into a send buffer. It is offered on an outgoing valid/ready interface and kept there until taken. The block then waits for a one-cycle response that either accepts or rejects it. A busy flag, visible in bit 12 of the lower half, stays high from launch until the message is finished. Rejected messages are offered again automatically, except start-up messages, which are dropped so that software can decide whether to reissue them. Two cases are resolved before the message leaves: a shorthand replaces the target number, and the INIT de-assert form is forced to an all-processors broadcast.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, reads of offset 0x300 and offset 0x310 both return 0 and `msg_valid` is 0.
- R2: A write to offset 0x300 stores vector (bits 7:0), message kind (10:8), logical addressing (11), level (14), trigger (15) and shorthand (19:18). A read of 0x300 returns those bits in place, with all other bits 0 apart from the busy flag in bit 12.
- R3: A write to offset 0x310 stores only bits 31:24 as the target number, and a read of 0x310 returns them with all other bits 0. Such a write launches no message.
- R4: A write to 0x300 with a non-reserved kind while not busy raises `msg_valid` and the busy flag in the cycle after the write edge. The outgoing fields equal the written ones, subject to R10 and R11.
- R5: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and all outgoing fields stay unchanged.
- R6: A response with `rsp_accept`=1 while waiting clears the busy flag and leaves `msg_valid` at 0.
- R7: A rejected message of kind 000 fixed, 001 lowest priority, 010 SMI, 100 NMI or 101 INIT is offered again, with `msg_valid`=1, in the cycle after the response.
- R8: A rejected message of kind 110 (start-up) is not offered again, and the busy flag returns to 0.
- R9: A write to 0x300 with the reserved kind 011 or 111 launches no message and leaves the busy flag at 0.
- R10: When the outgoing shorthand is nonzero (01 self, 10 all including self, 11 all excluding self), `msg_dest` is 0. With shorthand 00, `msg_dest` carries the stored target number.
- R11: A message of kind 101 with level 0 and trigger 1 goes out with shorthand 10 and `msg_dest` 0, whatever shorthand and target were written.
- R12: A write to 0x300 while busy launches nothing and leaves the in-flight message unchanged, but its fields are stored and read back.
- R13: Bit 12 of a write to 0x300 is ignored: it never sets the busy flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset, used for both write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| msg_valid | output | 1 | Outgoing message offered |
| msg_ready | input | 1 | Receiver takes the message |
| msg_vector | output | 8 | Outgoing vector |
| msg_mode | output | 3 | Outgoing message kind |
| msg_dest_logical | output | 1 | Outgoing addressing: 0 physical, 1 logical |
| msg_level | output | 1 | Outgoing level flag |
| msg_trigger | output | 1 | Outgoing trigger: 0 edge, 1 level |
| msg_shorthand | output | 2 | Outgoing resolved shorthand |
| msg_dest | output | 8 | Outgoing target number, 0 under a shorthand |
| rsp_valid | input | 1 | Response to the taken message |
| rsp_accept | input | 1 | Response kind: 1 accepted, 0 rejected |

## Verification
The launch path is driven with a table of commands that covers every non-reserved message kind. The commands use both addressing modes and all four shorthands, and include both the INIT assert and INIT de-assert forms. This separates a plain field copy from the shorthand target masking and from the forced broadcast. Directed cases then split the response paths: accept, rejection with a retry, and rejection of a start-up message without a retry. Further cases cover a reserved kind, a rewrite while busy that must not disturb the in-flight message, and a written busy bit that must read back as 0.

// File: rtl/ipi_pkg.sv
// Package: shared field positions, message kind codes and message type
// for the interprocessor interrupt command register.
// Assumes a 32-bit register port and 8-bit vector and target fields.
package ipi_pkg;

    localparam int VEC_W    = 8;
    localparam int DEST_W   = 8;
    localparam int MODE_W   = 3;
    localparam int SH_W     = 2;
    localparam int WORD_W   = 32;

    localparam int VEC_LSB  = 0;
    localparam int MODE_LSB = 8;
    localparam int LOG_BIT  = 11;
    localparam int BUSY_BIT = 12;
    localparam int LVL_BIT  = 14;
    localparam int TRG_BIT  = 15;
    localparam int SH_LSB   = 18;
    localparam int DEST_LSB = WORD_W - DEST_W;

    localparam logic [MODE_W-1:0] KIND_FIXED  = 3'b000;
    localparam logic [MODE_W-1:0] KIND_LOWPRI = 3'b001;
    localparam logic [MODE_W-1:0] KIND_SMI    = 3'b010;
    localparam logic [MODE_W-1:0] KIND_RSV_A  = 3'b011;
    localparam logic [MODE_W-1:0] KIND_NMI    = 3'b100;
    localparam logic [MODE_W-1:0] KIND_INIT   = 3'b101;
    localparam logic [MODE_W-1:0] KIND_START  = 3'b110;
    localparam logic [MODE_W-1:0] KIND_RSV_B  = 3'b111;

    localparam logic [SH_W-1:0] SH_NONE     = 2'b00;
    localparam logic [SH_W-1:0] SH_ALL_INCL = 2'b10;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              dest_logical;
        logic              level;
        logic              trigger;
        logic [SH_W-1:0]   shorthand;
        logic [DEST_W-1:0] dest;
    } ipi_msg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } send_state_e;

    function automatic logic kind_reserved(input logic [MODE_W-1:0] m);
        return (m == KIND_RSV_A) || (m == KIND_RSV_B);
    endfunction

endpackage

// File: rtl/ipi_field_store.sv
// Module: holds the software-visible command fields and serves reads.
// Assumes one access per cycle; rdata decodes addr combinationally.
// next_fields shows the fields as they will be after a write in flight,
// so that a launch sees the value being written.
module ipi_field_store
    import ipi_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
    parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              busy,
    output logic [WORD_W-1:0] rdata,
    output logic              low_wr,
    output ipi_msg_t          next_fields
);

    ipi_msg_t stored;
    logic     high_wr;

    assign low_wr  = wr_en && (addr == LOW_OFS);
    assign high_wr = wr_en && (addr == HIGH_OFS);

    // Decode a low-half write on top of the stored target number.
    always_comb begin
        next_fields = stored;
        if (low_wr) begin
            next_fields.vector       = wdata[VEC_LSB +: VEC_W];
            next_fields.mode         = wdata[MODE_LSB +: MODE_W];
            next_fields.dest_logical = wdata[LOG_BIT];
            next_fields.level        = wdata[LVL_BIT];
            next_fields.trigger      = wdata[TRG_BIT];
            next_fields.shorthand    = wdata[SH_LSB +: SH_W];
        end
        if (high_wr) begin
            next_fields.dest = wdata[DEST_LSB +: DEST_W];
        end
    end

    // Register the fields; the busy bit is never taken from wdata.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else begin
            stored <= next_fields;
        end
    end

    // Assemble read data for the addressed half.
    always_comb begin
        rdata = '0;
        if (addr == LOW_OFS) begin
            rdata[VEC_LSB +: VEC_W]   = stored.vector;
            rdata[MODE_LSB +: MODE_W] = stored.mode;
            rdata[LOG_BIT]            = stored.dest_logical;
            rdata[BUSY_BIT]           = busy;
            rdata[LVL_BIT]            = stored.level;
            rdata[TRG_BIT]            = stored.trigger;
            rdata[SH_LSB +: SH_W]     = stored.shorthand;
        end else if (addr == HIGH_OFS) begin
            rdata[DEST_LSB +: DEST_W] = stored.dest;
        end
    end

endmodule

// File: rtl/ipi_msg_build.sv
// Module: turns register fields into the message that goes out.
// Forces the INIT de-assert form to an all-processors broadcast and
// clears the target number whenever a shorthand is in use.
// Purely combinational.
module ipi_msg_build
    import ipi_pkg::*;
(
    input  ipi_msg_t fields,
    output ipi_msg_t msg,
    output logic     reserved
);

    logic deassert;

    assign deassert = (fields.mode == KIND_INIT) && !fields.level && fields.trigger;
    assign reserved = kind_reserved(fields.mode);

    // Resolve the shorthand, then mask the target under any shorthand.
    always_comb begin
        msg = fields;
        if (deassert) begin
            msg.shorthand = SH_ALL_INCL;
        end
        if (msg.shorthand != SH_NONE) begin
            msg.dest = '0;
        end
    end

endmodule

// File: rtl/ipi_send_ctrl.sv
// Module: launch, handshake and retry sequencing for one message.
// Assumes a response arrives only after the message has been taken;
// a response seen while still offering the message is ignored.
module ipi_send_ctrl
    import ipi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     launch_req,
    input  logic     launch_reserved,
    input  ipi_msg_t launch_msg,
    input  logic     msg_ready,
    input  logic     rsp_valid,
    input  logic     rsp_accept,
    output logic     msg_valid,
    output ipi_msg_t cur_msg,
    output logic     busy
);

    send_state_e state;

    assign busy      = (state != ST_IDLE);
    assign msg_valid = (state == ST_SEND);

    // Step the send sequence and capture the message at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_msg <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (launch_req && !launch_reserved) begin
                        cur_msg <= launch_msg;
                        state   <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (msg_ready) begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rsp_valid) begin
                        if (rsp_accept || (cur_msg.mode == KIND_START)) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_SEND;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ipi_cmd_reg.sv
// Module: top of the interprocessor interrupt command register.
// A low-half write is the send request; a high-half write only stores
// the target. Assumes a single clock domain and synchronous reset.
module ipi_cmd_reg
    import ipi_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] LOW_OFS  = 12'h300,
    parameter logic [ADDR_W-1:0] HIGH_OFS = 12'h310
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [7:0]        msg_vector,
    output logic [2:0]        msg_mode,
    output logic              msg_dest_logical,
    output logic              msg_level,
    output logic              msg_trigger,
    output logic [1:0]        msg_shorthand,
    output logic [7:0]        msg_dest,
    input  logic              rsp_valid,
    input  logic              rsp_accept
);

    logic     pend;
    logic     low_wr;
    logic     reserved;
    ipi_msg_t next_fields;
    ipi_msg_t built;
    ipi_msg_t cur_msg;

    ipi_field_store #(
        .ADDR_W   (ADDR_W),
        .LOW_OFS  (LOW_OFS),
        .HIGH_OFS (HIGH_OFS)
    ) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .busy        (pend),
        .rdata       (rdata),
        .low_wr      (low_wr),
        .next_fields (next_fields)
    );

    ipi_msg_build build_i (
        .fields   (next_fields),
        .msg      (built),
        .reserved (reserved)
    );

    ipi_send_ctrl ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .launch_req      (low_wr),
        .launch_reserved (reserved),
        .launch_msg      (built),
        .msg_ready       (msg_ready),
        .rsp_valid       (rsp_valid),
        .rsp_accept      (rsp_accept),
        .msg_valid       (msg_valid),
        .cur_msg         (cur_msg),
        .busy            (pend)
    );

    // Drive the outgoing fields from the send buffer.
    assign msg_vector       = cur_msg.vector;
    assign msg_mode         = cur_msg.mode;
    assign msg_dest_logical = cur_msg.dest_logical;
    assign msg_level        = cur_msg.level;
    assign msg_trigger      = cur_msg.trigger;
    assign msg_shorthand    = cur_msg.shorthand;
    assign msg_dest         = cur_msg.dest;

endmodule

// File: rtl/ipi_cmd_reg_chk.sv
// Checker: temporal properties of the command register, bound to the top.
// Assumes the pending flag of the top is named pend.
module ipi_cmd_reg_chk #(
    parameter int                ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] LOW_OFS = 12'h300
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [7:0]        msg_vector,
    input logic [2:0]        msg_mode,
    input logic [1:0]        msg_shorthand,
    input logic [7:0]        msg_dest,
    input logic              rsp_valid,
    input logic              rsp_accept,
    input logic              pend
);

    logic low_wr;
    logic rsv_kind;
    logic waiting;

    assign low_wr   = wr_en && (addr == LOW_OFS);
    assign rsv_kind = (wdata[10:8] == 3'b011) || (wdata[10:8] == 3'b111);
    assign waiting  = pend && !msg_valid;

    p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr && !pend && !rsv_kind |=> msg_valid && pend);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
            && $stable(msg_mode) && $stable(msg_shorthand) && $stable(msg_dest));

    p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && rsp_valid && rsp_accept |=> !pend && !msg_valid);

    p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && rsp_valid && !rsp_accept && (msg_mode != 3'b110) |=> msg_valid);

    p_no_retry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        waiting && rsp_valid && !rsp_accept && (msg_mode == 3'b110) |=> !pend);

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        low_wr && !pend && rsv_kind |=> !pend && !msg_valid);

    p_dest_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_shorthand != 2'b00) |-> msg_dest == 8'h00);

    p_valid_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> pend);

endmodule

bind ipi_cmd_reg ipi_cmd_reg_chk #(
    .ADDR_W  (ADDR_W),
    .LOW_OFS (LOW_OFS)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .addr          (addr),
    .wdata         (wdata),
    .msg_valid     (msg_valid),
    .msg_ready     (msg_ready),
    .msg_vector    (msg_vector),
    .msg_mode      (msg_mode),
    .msg_shorthand (msg_shorthand),
    .msg_dest      (msg_dest),
    .rsp_valid     (rsp_valid),
    .rsp_accept    (rsp_accept),
    .pend          (pend)
);

// File: tb/ipi_cmd_reg_tb_top.sv
// Bench: table-driven launch checks, then directed reset and corner cases.
module ipi_cmd_reg_tb_top;

    localparam logic [11:0] LOW  = 12'h300;
    localparam logic [11:0] HIGH = 12'h310;
    localparam logic [31:0] LOW_MASK = 32'h000C_CFFF;
    localparam logic [31:0] BUSY = 32'h0000_1000;

    typedef struct packed {
        logic [7:0]  dest;
        logic [31:0] low;
        logic [1:0]  exp_sh;
        logic [7:0]  exp_dest;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t TBL [NVEC] = '{
        '{8'h2A, 32'h0000_4041, 2'b00, 8'h2A},
        '{8'h07, 32'h0000_4999, 2'b00, 8'h07},
        '{8'h55, 32'h0004_4400, 2'b01, 8'h00},
        '{8'h10, 32'h000C_4200, 2'b11, 8'h00},
        '{8'h33, 32'h0000_8500, 2'b10, 8'h00},
        '{8'h44, 32'h0008_4500, 2'b10, 8'h00},
        '{8'h3C, 32'h0000_469A, 2'b00, 8'h3C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic        msg_dest_logical;
    logic        msg_level;
    logic        msg_trigger;
    logic [1:0]  msg_shorthand;
    logic [7:0]  msg_dest;
    logic        rsp_valid = 1'b0;
    logic        rsp_accept = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ipi_cmd_reg dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .addr             (addr),
        .wdata            (wdata),
        .rdata            (rdata),
        .msg_valid        (msg_valid),
        .msg_ready        (msg_ready),
        .msg_vector       (msg_vector),
        .msg_mode         (msg_mode),
        .msg_dest_logical (msg_dest_logical),
        .msg_level        (msg_level),
        .msg_trigger      (msg_trigger),
        .msg_shorthand    (msg_shorthand),
        .msg_dest         (msg_dest),
        .rsp_valid        (rsp_valid),
        .rsp_accept       (rsp_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic take();
        @(negedge clk);
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic respond(input logic acc);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_accept = acc;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_accept = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd_check("R1 low", LOW, 32'h0);
        rd_check("R1 high", HIGH, 32'h0);
        check("R1 valid", {31'b0, msg_valid}, 32'h0);

        // R3: high write stores target only and launches nothing
        wr(HIGH, 32'hAB12_3456);
        check("R3 no launch", {31'b0, msg_valid}, 32'h0);
        rd_check("R3 high", HIGH, 32'hAB00_0000);
        rd_check("R3 low", LOW, 32'h0);

        // R2 R4 R10 R11 R6: table of commands
        for (int i = 0; i < NVEC; i++) begin
            wr(HIGH, {TBL[i].dest, 24'h0});
            wr(LOW, TBL[i].low);
            check("R4 valid", {31'b0, msg_valid}, 32'h1);
            check("R4 vector", {24'b0, msg_vector}, {24'b0, TBL[i].low[7:0]});
            check("R4 mode", {29'b0, msg_mode}, {29'b0, TBL[i].low[10:8]});
            check("R4 logical", {31'b0, msg_dest_logical}, {31'b0, TBL[i].low[11]});
            check("R4 level", {31'b0, msg_level}, {31'b0, TBL[i].low[14]});
            check("R4 trigger", {31'b0, msg_trigger}, {31'b0, TBL[i].low[15]});
            check("R10 R11 shorthand", {30'b0, msg_shorthand}, {30'b0, TBL[i].exp_sh});
            check("R10 R11 dest", {24'b0, msg_dest}, {24'b0, TBL[i].exp_dest});
            rd_check("R2 readback busy", LOW, (TBL[i].low & LOW_MASK) | BUSY);
            take();
            respond(1'b1);
            check("R6 valid after accept", {31'b0, msg_valid}, 32'h0);
            rd_check("R6 status cleared", LOW, TBL[i].low & LOW_MASK);
        end

        // R5 R7: hold while not ready, reject fixed then retry
        wr(HIGH, 32'h0900_0000);
        wr(LOW, 32'h0000_4077);
        repeat (3) @(negedge clk);
        check("R5 held valid", {31'b0, msg_valid}, 32'h1);
        check("R5 held vector", {24'b0, msg_vector}, 32'h77);
        take();
        check("R7 waiting", {31'b0, msg_valid}, 32'h0);
        respond(1'b0);
        check("R7 resent", {31'b0, msg_valid}, 32'h1);
        check("R7 resent vector", {24'b0, msg_vector}, 32'h77);
        rd_check("R7 still busy", LOW, 32'h0000_5077);
        take();
        respond(1'b1);
        rd_check("R7 done", LOW, 32'h0000_4077);

        // R8: rejected start-up is not resent
        wr(LOW, 32'h0000_4620);
        take();
        respond(1'b0);
        check("R8 no resend", {31'b0, msg_valid}, 32'h0);
        rd_check("R8 status", LOW, 32'h0000_4620);
        repeat (2) @(negedge clk);
        check("R8 still quiet", {31'b0, msg_valid}, 32'h0);

        // R9 R13: reserved kinds with bit 12 written
        wr(LOW, 32'h0000_5301);
        check("R9 no launch 011", {31'b0, msg_valid}, 32'h0);
        rd_check("R13 busy ignored", LOW, 32'h0000_4301);
        wr(LOW, 32'h0000_5701);
        check("R9 no launch 111", {31'b0, msg_valid}, 32'h0);
        rd_check("R9 R13 status", LOW, 32'h0000_4701);

        // R12: rewrite while busy
        wr(LOW, 32'h0004_4011);
        check("R12 launched", {31'b0, msg_valid}, 32'h1);
        wr(LOW, 32'h0000_4122);
        check("R12 vector kept", {24'b0, msg_vector}, 32'h11);
        check("R12 mode kept", {29'b0, msg_mode}, 32'h0);
        check("R12 shorthand kept", {30'b0, msg_shorthand}, 32'h1);
        rd_check("R12 fields stored", LOW, 32'h0000_5122);
        take();
        respond(1'b1);
        check("R12 no second launch", {31'b0, msg_valid}, 32'h0);
        rd_check("R12 idle", LOW, 32'h0000_4122);

        finish_run();
    end

endmodule